// File: doc/BRIEF.md
# Frame buffer scan-out address generator

This block sits between a register port and a memory fetch path of a fixed-mode true-colour display controller. Software programs two registers: a frame base (of which only the eleven upper address bits are kept, so a frame starts on a 2 MiB boundary) and a control word with a display-enable bit and a half-turn rotation bit. On each start-of-frame pulse the block latches the base and the rotation setting. It then issues one byte address per pixel over a valid/ready request channel.

Memory is laid out with a fixed stride of 1024 words per row. Only the first 640 words of each of the 480 rows are fetched. With rotation set, the whole walk is reversed, from the last pixel of the last row back to the first. Returned 32-bit words arrive in request order. The block splits each word into 8-bit red, green and blue outputs with a one-cycle-delayed valid strobe. The top byte of the word is discarded.

The register port decodes in one of two offset styles: word offsets (control at offset 1) or byte offsets (control at offset 4, the index shifted left by two). The base register is at offset 0 in both styles.

Top module: `fb_scan_top`

## Requirements
- R1: After reset both registers read as zero, no request is valid and the pixel outputs (valid, red, green, blue) are zero.
- R2: A write to the base register (offset 0) keeps only data bits 31:21. A read of offset 0 returns those bits with bits 20:0 as zero.
- R3: With byte_mode low the control register is at offset 1; with byte_mode high it is at offset 4. Only data bits 1:0 are stored, and other bits read as zero. A write to any offset that is neither 0 nor the active control offset changes nothing, and reading such an offset returns zero.
- R4: Control bit 0 is the display enable. While it is 0, req_valid stays low and pix_valid, pix_red, pix_green and pix_blue are zero, even when response words arrive.
- R5: Without rotation, a frame's requests carry byte addresses base + (y*1024 + x)*4. x runs 0..H_ACTIVE-1 fastest and y runs 0..V_ACTIVE-1; the defaults are 640 and 480.
- R6: When control bit 1 is set at start of frame, the request order is fully reversed. The first request is (H_ACTIVE-1, V_ACTIVE-1), x decreases fastest, and the last request is (0, 0).
- R7: The base and rotation values are sampled only on a start-of-frame pulse. A register write during a frame first affects the next frame.
- R8: While req_valid is high and req_ready is low, req_addr and req_valid hold. The address moves on only after an accepted request.
- R9: One cycle after a response word is presented with rsp_valid while the display is enabled, pix_valid is 1 and red, green and blue equal word bits 23:16, 15:8 and 7:0. Bits 31:24 have no effect.
- R10: After the last pixel of a frame is accepted, no further request is issued until the next start-of-frame pulse.
- R11: A start-of-frame pulse during an unfinished frame abandons it and restarts the scan from its first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_mode | input | 1 | Register offset style: 0 word offsets, 1 byte offsets |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_off |
| sof | input | 1 | Start-of-frame pulse |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Fetch request accepted |
| req_addr | output | 32 | Fetch byte address |
| rsp_valid | input | 1 | Returned pixel word valid |
| rsp_data | input | 32 | Returned pixel word |
| pix_valid | output | 1 | Pixel output valid |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |

## Verification
The hardest case to reach from the ports is a register write that lands while a frame is being fetched under backpressure. The write must not disturb the remaining addresses of that frame, yet it must steer the next one. The bench starts a frame with a stalling ready pattern, rewrites the base in parallel a few cycles later, and scores every remaining address against the old base before it scores the following frame against the new one. Restart in mid-frame is reached by running part of a frame unchecked and then sending a second pulse, after which a complete frame must follow.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
    localparam int WORD_W      = 32;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_RT_BIT = 1;
    localparam int CTRL_IDX    = 1;
    localparam int CHAN_W      = 8;

    typedef struct packed {
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] green;
        logic [CHAN_W-1:0] blue;
    } rgb_t;
endpackage

// File: rtl/fb_regs.sv
module fb_regs
    import fb_scan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEEP   = 11,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              wr,
    input  logic [OFF_W-1:0]  off,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] base_addr,
    output logic              en,
    output logic              rot
);
    localparam int LOW = ADDR_W - KEEP;

    typedef struct packed {
        logic [KEEP-1:0] base;
        logic [1:0]      ctrl;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    base_hit, ctrl_hit;

    always_comb begin
        base_hit = (off == '0);
        ctrl_hit = (off == (byte_mode ? OFF_W'(CTRL_IDX << 2) : OFF_W'(CTRL_IDX)));
        st_d = st_q;
        if (wr && base_hit) st_d.base = wdata[ADDR_W-1:LOW];
        if (wr && ctrl_hit) st_d.ctrl = wdata[1:0];
        if (base_hit)      rdata = {st_q.base, {LOW{1'b0}}};
        else if (ctrl_hit) rdata = ADDR_W'(st_q.ctrl);
        else               rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_addr = {st_q.base, {LOW{1'b0}}};
    assign en        = st_q.ctrl[CTRL_EN_BIT];
    assign rot       = st_q.ctrl[CTRL_RT_BIT];

    assert_base_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == '0) |=> (base_addr == {$past(wdata[ADDR_W-1:LOW]), {LOW{1'b0}}}));

    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl_hit) |=> ({rot, en} == $past(wdata[1:0])));

    assert_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ctrl_hit && off != '0) |=> ($stable(base_addr) && $stable(en) && $stable(rot)));
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int H_ACTIVE  = 640,
    parameter int V_ACTIVE  = 480,
    parameter int ROW_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rot_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              sof,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int X_W    = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1;
    localparam int Y_W    = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1;
    localparam int ROW_SH = $clog2(ROW_WORDS);
    localparam logic [X_W-1:0] XMAX = X_W'(H_ACTIVE - 1);
    localparam logic [Y_W-1:0] YMAX = Y_W'(V_ACTIVE - 1);

    typedef struct packed {
        logic              active;
        logic              rot;
        logic [ADDR_W-1:0] base;
        logic [X_W-1:0]    x;
        logic [Y_W-1:0]    y;
    } scan_st_t;

    scan_st_t         st_d, st_q;
    logic             accept, last;
    logic [ADDR_W-1:0] word_off;

    always_comb begin
        accept = req_valid && req_ready;
        last   = st_q.rot ? (st_q.x == '0 && st_q.y == '0)
                          : (st_q.x == XMAX && st_q.y == YMAX);
        st_d = st_q;
        if (!en) begin
            st_d.active = 1'b0;
        end else if (sof) begin
            st_d.active = 1'b1;
            st_d.base   = base_in;
            st_d.rot    = rot_in;
            st_d.x      = rot_in ? XMAX : '0;
            st_d.y      = rot_in ? YMAX : '0;
        end else if (accept) begin
            if (last) begin
                st_d.active = 1'b0;
            end else if (!st_q.rot) begin
                if (st_q.x == XMAX) begin
                    st_d.x = '0;
                    st_d.y = st_q.y + 1'b1;
                end else begin
                    st_d.x = st_q.x + 1'b1;
                end
            end else begin
                if (st_q.x == '0) begin
                    st_d.x = XMAX;
                    st_d.y = st_q.y - 1'b1;
                end else begin
                    st_d.x = st_q.x - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_off  = (ADDR_W'(st_q.y) << ROW_SH) + ADDR_W'(st_q.x);
    assign req_addr  = st_q.base + (word_off << 2);
    assign req_valid = st_q.active && en;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !sof && en) |=> (!en || (req_valid && $stable(req_addr))));

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !sof) |=> (!req_valid || !$stable(req_addr)));

    assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00));

    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req_valid);
endmodule

// File: rtl/fb_pix_unpack.sv
module fb_pix_unpack
    import fb_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              pix_valid,
    output rgb_t              pix
);
    typedef struct packed {
        logic vld;
        rgb_t col;
    } pix_st_t;

    pix_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (en && rsp_valid) begin
            st_d.vld       = 1'b1;
            st_d.col.red   = rsp_data[23:16];
            st_d.col.green = rsp_data[15:8];
            st_d.col.blue  = rsp_data[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_valid = st_q.vld;
    assign pix       = st_q.col;

    assert_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pix_valid && pix == '0));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rsp_valid) |=> (pix_valid && pix.blue == $past(rsp_data[7:0])));
endmodule

// File: rtl/fb_scan_top.sv
module fb_scan_top
    import fb_scan_pkg::*;
#(
    parameter int H_ACTIVE  = 640,
    parameter int V_ACTIVE  = 480,
    parameter int ROW_WORDS = 1024,
    parameter int BASE_KEEP = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_mode,
    input  logic        reg_wr,
    input  logic [2:0]  reg_off,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sof,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [31:0] req_addr,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_data,
    output logic        pix_valid,
    output logic [7:0]  pix_red,
    output logic [7:0]  pix_green,
    output logic [7:0]  pix_blue
);
    logic [WORD_W-1:0] base_addr;
    logic              en, rot;
    rgb_t              pix;

    fb_regs #(.ADDR_W(WORD_W), .KEEP(BASE_KEEP), .OFF_W(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr(reg_wr),
        .off(reg_off), .wdata(reg_wdata), .rdata(reg_rdata),
        .base_addr(base_addr), .en(en), .rot(rot)
    );

    fb_addr_gen #(.ADDR_W(WORD_W), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
                  .ROW_WORDS(ROW_WORDS)) u_addr (
        .clk(clk), .rst_n(rst_n), .en(en), .rot_in(rot), .base_in(base_addr),
        .sof(sof), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr)
    );

    fb_pix_unpack u_pix (
        .clk(clk), .rst_n(rst_n), .en(en), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .pix_valid(pix_valid), .pix(pix)
    );

    assign pix_red   = pix.red;
    assign pix_green = pix.green;
    assign pix_blue  = pix.blue;
endmodule

// File: tb/fb_scan_top_test.sv
module fb_scan_top_test;
    localparam int H = 6;
    localparam int V = 3;

    logic        clk = 0, rst_n = 0, byte_mode = 0, reg_wr = 0, sof = 0;
    logic [2:0]  reg_off = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, req_addr, rsp_data = 0;
    logic        req_valid, req_ready = 0, rsp_valid = 0, pix_valid;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int total = 0, bad = 0;
    bit chk_en = 1, done = 0;
    logic [31:0] addr_q[$];
    logic [23:0] pix_q[$];

    always #2 clk = ~clk;

    fb_scan_top #(.H_ACTIVE(H), .V_ACTIVE(V)) uut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .reg_wr(reg_wr),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sof(sof), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pix_valid(pix_valid),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // scoreboard monitors
    initial forever begin
        @(negedge clk);
        if (rst_n && chk_en && req_valid && req_ready) begin
            if (addr_q.size() == 0) check(0, "R10 unexpected request", req_addr, 32'h0);
            else begin
                logic [31:0] e;
                e = addr_q.pop_front();
                check(req_addr == e, "R5/R6/R7/R8 address", req_addr, e);
            end
        end
        if (rst_n && pix_valid) begin
            if (pix_q.size() == 0) check(0, "R4 unexpected pixel", {8'h0, pix_red, pix_green, pix_blue}, 32'h0);
            else begin
                logic [23:0] p;
                p = pix_q.pop_front();
                check({pix_red, pix_green, pix_blue} == p, "R9 colour split",
                      {8'h0, pix_red, pix_green, pix_blue}, {8'h0, p});
            end
        end
    end

    // stalling ready pattern for R8
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk); #1;
            rc++;
            req_ready = (rc % 3) != 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 0);
        finish_run();
    end

    task automatic wr_reg(input logic [2:0] off, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_off = off; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_off = 0;
    endtask

    task automatic rd_check(input logic [2:0] off, input logic [31:0] exp, input string req);
        reg_off = off; #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic pulse_sof();
        @(posedge clk); #1; sof = 1;
        @(posedge clk); #1; sof = 0;
    endtask

    task automatic run_frame(input logic [31:0] base, input bit rot);
        for (int k = 0; k < H * V; k++) begin
            int x, y;
            x = rot ? (H - 1 - (k % H)) : (k % H);
            y = rot ? (V - 1 - (k / H)) : (k / H);
            addr_q.push_back(base + 32'((y * 1024 + x) * 4));
        end
        pulse_sof();
        chk_en = 1;
        while (addr_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(req_valid == 0, "R10 idle after last pixel", {31'h0, req_valid}, 0);
    endtask

    task automatic send_pix(input logic [31:0] w, input bit expect_out);
        @(posedge clk); #1;
        rsp_valid = 1; rsp_data = w;
        if (expect_out) pix_q.push_back(w[23:0]);
        @(posedge clk); #1;
        rsp_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(req_valid == 0, "R1 no request", {31'h0, req_valid}, 0);
        check({pix_valid, pix_red, pix_green, pix_blue} == 0, "R1 pixel zero",
              {7'h0, pix_valid, pix_red, pix_green, pix_blue}, 0);
        rd_check(0, 0, "R1 base zero");
        rd_check(1, 0, "R1 ctrl zero");
        rst_n = 1;

        // R2 base keep
        wr_reg(0, 32'hFFFF_FFFF);
        rd_check(0, 32'hFFE0_0000, "R2 base low bits");
        // R3 word mode control
        wr_reg(1, 32'hFFFF_FFFC);
        rd_check(1, 32'h0, "R3 ctrl upper bits dropped");
        wr_reg(1, 32'h1);
        rd_check(1, 32'h1, "R3 ctrl word offset");
        wr_reg(4, 32'h3);
        rd_check(1, 32'h1, "R3 offset 4 ignored in word mode");
        rd_check(4, 32'h0, "R3 offset 4 reads zero in word mode");
        byte_mode = 1;
        wr_reg(4, 32'h3);
        rd_check(4, 32'h3, "R3 ctrl byte offset");
        rd_check(1, 32'h0, "R3 offset 1 reads zero in byte mode");
        wr_reg(2, 32'h0);
        rd_check(4, 32'h3, "R3 stray write ignored");
        rd_check(0, 32'hFFE0_0000, "R3 stray write base kept");
        wr_reg(4, 32'h1);
        byte_mode = 0;

        // R5 normal frame
        wr_reg(0, 32'h0020_0000);
        run_frame(32'h0020_0000, 0);
        // R6 rotated frame
        wr_reg(1, 32'h3);
        run_frame(32'h0020_0000, 1);
        wr_reg(1, 32'h1);

        // R7 mid-frame write affects next frame only
        fork
            run_frame(32'h0020_0000, 0);
            begin
                repeat (6) @(posedge clk);
                wr_reg(0, 32'h0420_0000);
            end
        join
        rd_check(0, 32'h0420_0000, "R7 new base stored");
        run_frame(32'h0420_0000, 0);

        // R11 restart mid-frame
        chk_en = 0;
        pulse_sof();
        repeat (7) @(posedge clk);
        run_frame(32'h0420_0000, 0);
        check(addr_q.size() == 0, "R11 full frame after restart", addr_q.size(), 0);

        // R9 colour unpack, top byte ignored
        send_pix(32'hA512_3456, 1);
        send_pix(32'h00FF_00FF, 1);
        send_pix(32'h5A00_FF00, 1);
        repeat (3) @(negedge clk);
        check(pix_q.size() == 0, "R9 all pixels seen", pix_q.size(), 0);

        // R4 disabled display
        wr_reg(1, 32'h0);
        pulse_sof();
        repeat (4) @(negedge clk);
        check(req_valid == 0, "R4 no request when disabled", {31'h0, req_valid}, 0);
        @(posedge clk); #1; rsp_valid = 1; rsp_data = 32'h00AB_CDEF;
        @(negedge clk);
        @(negedge clk);
        check({pix_valid, pix_red, pix_green, pix_blue} == 0, "R4 colours zero when disabled",
              {7'h0, pix_valid, pix_red, pix_green, pix_blue}, 0);
        rsp_valid = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule